// File: doc/BRIEF.md
# Handshaked Byte Mailbox

This block moves bytes one at a time between a host processor and a pair of local byte buffers. The host sees three registers: a port B register carrying three active-low handshake lines, an 8-bit shift data register, and a mode register that picks the direction. There is also a write-only flag-clear address. The host owns the in-progress and acknowledge lines. The block owns the request line. No serial shift clock is used. Each time the host changes the in-progress/acknowledge pair while a transfer is open, one byte moves.

In host-to-device mode, every handshake step copies the shift register into a 16-entry outgoing buffer. In device-to-host mode, the device side first fills an incoming buffer of up to 128 bytes and starts a packet with a length. Each step then loads the next byte into the shift register. The block drops the request line back to idle once the last byte has been handed over. A single shift interrupt flag marks each byte moved, each packet start and each transfer end. A one-cycle strobe tells the device side that the host delivered a non-empty packet.

Top module: `hs_byte_mailbox`

## Requirements
- R1: After reset, port B reads 0xFF, the shift register reads 0x00, the interrupt flag is clear, the outgoing count is 0 and the packet strobe is low.
- R2: Port B bit 3 is the request line and is driven only by the block. Host writes to bit 3 are ignored. Bit 4 (acknowledge) and bit 5 (in-progress) are host-driven. All three are active low. Bits 0-2 and 6-7 read back as written.
- R3: A port B write moves a byte only when bit 5 of the written value is 0 and bits 5:4 differ from the port B value held before the write. A write that leaves bits 5:4 unchanged moves nothing and leaves the count unchanged.
- R4: When mode register bit 4 is 1 (host-to-device), each step stores the shift register at the outgoing index, increments the index (reported as the outgoing count) and sets the interrupt flag.
- R5: The outgoing buffer holds 16 bytes. A step taken while 16 are held is dropped: the count stays 16, no entry changes and the flag is not set.
- R6: When mode register bit 4 is 0 (device-to-host), each step loads the shift register from the incoming buffer at the read index, advances the index and sets the flag. The step that hands over the byte at index length-1 drives the request line high. Steps past the length change nothing.
- R7: A packet start (go strobe with a length) stores the length, clears the read index, drives the request line low and sets the interrupt flag on the next edge.
- R8: A port B write that drives bit 5 low while it was high opens a transfer. It clears both buffer indices before that write's own step is applied, so the first byte goes to or comes from index 0.
- R9: A port B write that drives bit 5 high while it was low always sets the flag. It pulses the packet strobe for exactly one cycle only if the outgoing count is nonzero.
- R10: Writing a value with bit 2 set to address 3 clears the flag. Writing with bit 2 clear leaves it unchanged. A set in the same cycle wins over the clear.
- R11: Address 0 is port B, address 1 is the shift register (directly writable), address 2 is the mode register and address 3 is the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 2 | Host register address |
| reg_wdata_i | input | 8 | Host write data |
| portb_o | output | 8 | Port B value including the request line |
| shift_o | output | 8 | Shift data register |
| sr_irq_o | output | 1 | Shift interrupt flag |
| pkt_rcvd_o | output | 1 | One-cycle strobe: host delivered a non-empty packet |
| out_count_o | output | 5 | Number of bytes in the outgoing buffer |
| out_raddr_i | input | 4 | Outgoing buffer read address |
| out_rdata_o | output | 8 | Outgoing buffer read data |
| in_we_i | input | 1 | Incoming buffer write strobe |
| in_waddr_i | input | 7 | Incoming buffer write address |
| in_wdata_i | input | 8 | Incoming buffer write data |
| in_go_i | input | 1 | Start a device-to-host packet |
| in_len_i | input | 8 | Packet length for in_go_i |

## Verification
The handshake is driven with acknowledge-only toggles, in-progress edges and repeated writes of an unchanged pair. This separates pair-change detection from simple write detection, and transfer open and close from byte steps. Both directions run with random byte values, lengths of 1 to 20 and random values on the unrelated port B bits. This shows that the index resets at each open and that the request line releases exactly at the last byte. Directed runs of 18 steps in host-to-device mode, steps past the end of an incoming packet, and a transfer closed with an empty outgoing buffer separate the drop and stop behaviour from the plain stepping path.

// File: rtl/hs_mbx_pkg.sv
package hs_mbx_pkg;
  typedef enum logic [1:0] {
    RA_PORTB = 2'd0,
    RA_SHIFT = 2'd1,
    RA_MODE  = 2'd2,
    RA_FLAG  = 2'd3
  } reg_addr_e;

  localparam int DW        = 8;
  localparam int REQ_BIT   = 3;
  localparam int ACK_BIT   = 4;
  localparam int BUSY_BIT  = 5;
  localparam int DIR_BIT   = 4;
  localparam int FCLR_BIT  = 2;
  localparam logic [DW-1:0] PORTB_IDLE = 8'hFF;
endpackage

// File: rtl/hs_mbx_hsk.sv
module hs_mbx_hsk
  import hs_mbx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] host_bits_o,
  output logic          open_o,
  output logic          step_o,
  output logic          close_o
);
  logic [DW-1:0] bits_q;
  logic          pair_diff;

  assign pair_diff = wdata_i[BUSY_BIT:ACK_BIT] != bits_q[BUSY_BIT:ACK_BIT];
  assign open_o    = wr_i && !wdata_i[BUSY_BIT] && bits_q[BUSY_BIT];
  assign close_o   = wr_i && wdata_i[BUSY_BIT] && !bits_q[BUSY_BIT];
  assign step_o    = wr_i && !wdata_i[BUSY_BIT] && pair_diff;
  assign host_bits_o = bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= PORTB_IDLE;
    else if (wr_i) bits_q <= wdata_i;
  end
endmodule

// File: rtl/hs_mbx_outbuf.sv
module hs_mbx_outbuf #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          accept_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q, cnt_eff;

  assign cnt_eff  = clr_i ? '0 : cnt_q;
  assign accept_o = push_i && (cnt_eff < CW'(DEPTH));
  assign count_o  = cnt_q;
  assign rdata_o  = mem_q[raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= accept_o ? cnt_eff + CW'(1) : cnt_eff;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (accept_o && cnt_eff == CW'(i)) mem_q[i] <= data_i;
    end
  end
endmodule

// File: rtl/hs_mbx_inbuf.sv
module hs_mbx_inbuf #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          go_i,
  input  logic [LW-1:0] len_i,
  input  logic          clr_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          accept_o,
  output logic          req_n_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [LW-1:0] idx_q, idx_eff, len_q;
  logic          req_n_q;

  assign idx_eff  = clr_i ? '0 : idx_q;
  assign accept_o = pop_i && !go_i && (idx_eff < len_q);
  assign rdata_o  = mem_q[idx_eff[AW-1:0]];
  assign req_n_o  = req_n_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      len_q   <= '0;
      req_n_q <= 1'b1;
    end else if (go_i) begin
      idx_q   <= '0;
      len_q   <= (len_i > LW'(DEPTH)) ? LW'(DEPTH) : len_i;
      req_n_q <= 1'b0;
    end else begin
      idx_q <= accept_o ? idx_eff + LW'(1) : idx_eff;
      if (accept_o && (idx_eff + LW'(1) >= len_q)) req_n_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hs_byte_mailbox.sv
module hs_byte_mailbox
  import hs_mbx_pkg::*;
#(
  parameter int OUT_DEPTH = 16,
  parameter int IN_DEPTH  = 128
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           reg_we_i,
  input  logic [1:0]                     reg_addr_i,
  input  logic [7:0]                     reg_wdata_i,
  output logic [7:0]                     portb_o,
  output logic [7:0]                     shift_o,
  output logic                           sr_irq_o,
  output logic                           pkt_rcvd_o,
  output logic [$clog2(OUT_DEPTH+1)-1:0] out_count_o,
  input  logic [$clog2(OUT_DEPTH)-1:0]   out_raddr_i,
  output logic [7:0]                     out_rdata_o,
  input  logic                           in_we_i,
  input  logic [$clog2(IN_DEPTH)-1:0]    in_waddr_i,
  input  logic [7:0]                     in_wdata_i,
  input  logic                           in_go_i,
  input  logic [$clog2(IN_DEPTH+1)-1:0]  in_len_i
);
  logic [DW-1:0] host_bits, in_rdata;
  logic          hs_open, hs_step, hs_close;
  logic          push_ok, pop_ok, req_n;
  logic          dir_out_q, flag_q, pkt_q;
  logic [DW-1:0] sr_q;
  logic          wr_portb, wr_shift, wr_mode, wr_flag;

  assign wr_portb = reg_we_i && reg_addr_i == RA_PORTB;
  assign wr_shift = reg_we_i && reg_addr_i == RA_SHIFT;
  assign wr_mode  = reg_we_i && reg_addr_i == RA_MODE;
  assign wr_flag  = reg_we_i && reg_addr_i == RA_FLAG;

  hs_mbx_hsk u_hsk (
    .clk_i, .rst_ni,
    .wr_i(wr_portb), .wdata_i(reg_wdata_i),
    .host_bits_o(host_bits),
    .open_o(hs_open), .step_o(hs_step), .close_o(hs_close)
  );

  hs_mbx_outbuf #(.DEPTH(OUT_DEPTH), .DW(DW)) u_out (
    .clk_i, .rst_ni,
    .clr_i(hs_open), .push_i(hs_step && dir_out_q), .data_i(sr_q),
    .raddr_i(out_raddr_i), .rdata_o(out_rdata_o),
    .count_o(out_count_o), .accept_o(push_ok)
  );

  hs_mbx_inbuf #(.DEPTH(IN_DEPTH), .DW(DW)) u_in (
    .clk_i, .rst_ni,
    .we_i(in_we_i), .waddr_i(in_waddr_i), .wdata_i(in_wdata_i),
    .go_i(in_go_i), .len_i(in_len_i),
    .clr_i(hs_open), .pop_i(hs_step && !dir_out_q),
    .rdata_o(in_rdata), .accept_o(pop_ok), .req_n_o(req_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_out_q <= 1'b0;
      sr_q      <= '0;
      flag_q    <= 1'b0;
      pkt_q     <= 1'b0;
    end else begin
      if (wr_mode) dir_out_q <= reg_wdata_i[DIR_BIT];
      if (pop_ok)        sr_q <= in_rdata;
      else if (wr_shift) sr_q <= reg_wdata_i;
      // set beats clear
      if (push_ok || pop_ok || hs_close || in_go_i) flag_q <= 1'b1;
      else if (wr_flag && reg_wdata_i[FCLR_BIT])    flag_q <= 1'b0;
      pkt_q <= hs_close && (out_count_o != '0);
    end
  end

  always_comb begin
    portb_o          = host_bits;
    portb_o[REQ_BIT] = req_n;
  end
  assign shift_o    = sr_q;
  assign sr_irq_o   = flag_q;
  assign pkt_rcvd_o = pkt_q;
endmodule

// File: rtl/hs_mbx_chk.sv
module hs_mbx_chk #(
  parameter int OUT_DEPTH = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           reg_we_i,
  input logic [1:0]                     reg_addr_i,
  input logic [7:0]                     portb_o,
  input logic                           sr_irq_o,
  input logic                           pkt_rcvd_o,
  input logic [$clog2(OUT_DEPTH+1)-1:0] out_count_o,
  input logic                           in_go_i
);
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_count_o <= ($clog2(OUT_DEPTH+1))'(OUT_DEPTH));

  assert_go_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_go_i |=> (!portb_o[3] && sr_irq_o));

  assert_pkt_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_rcvd_o |-> sr_irq_o);

  assert_pkt_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_rcvd_o |=> !pkt_rcvd_o);

  assert_portb_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == 2'd0) && !in_go_i |=> $stable(portb_o));

  assert_cnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == 2'd0) |=> $stable(out_count_o));
endmodule

bind hs_byte_mailbox hs_mbx_chk #(.OUT_DEPTH(OUT_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .portb_o(portb_o), .sr_irq_o(sr_irq_o), .pkt_rcvd_o(pkt_rcvd_o),
  .out_count_o(out_count_o), .in_go_i(in_go_i)
);

// File: tb/hs_byte_mailbox_tb_top.sv
module hs_byte_mailbox_tb_top;
  logic       clk = 0, rst_n = 0;
  logic       reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] portb, shift_v, out_rdata;
  logic       irq, pkt;
  logic [4:0] out_count;
  logic [3:0] out_raddr = 0;
  logic       in_we = 0, in_go = 0;
  logic [6:0] in_waddr = 0;
  logic [7:0] in_wdata = 0, in_len = 0;

  always #2.5 clk = ~clk;

  hs_byte_mailbox dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .portb_o(portb), .shift_o(shift_v), .sr_irq_o(irq),
    .pkt_rcvd_o(pkt), .out_count_o(out_count), .out_raddr_i(out_raddr),
    .out_rdata_o(out_rdata), .in_we_i(in_we), .in_waddr_i(in_waddr),
    .in_wdata_i(in_wdata), .in_go_i(in_go), .in_len_i(in_len)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_pb = 8'hFF, m_sr = 0, m_obuf [16], m_ibuf [128];
  logic       m_req = 1, m_flag = 0, m_dir = 0, m_pkt = 0;
  int         m_cnt = 0, m_len = 0, m_ridx = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    logic [7:0] epb;
    epb = m_pb; epb[3] = m_req;
    #1;
    chk(portb == epb, {req, " portb"}, portb, epb);
    chk(shift_v == m_sr, {req, " shift"}, shift_v, m_sr);
    chk(irq == m_flag, {req, " irq"}, irq, m_flag);
    chk(out_count == m_cnt[4:0], {req, " count"}, out_count, m_cnt);
    chk(pkt == m_pkt, {req, " pkt"}, pkt, m_pkt);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  // port B write with model update
  task automatic hb(input logic [7:0] v, input string req);
    bit chg, opn, cls;
    chg = v[5:4] != m_pb[5:4];
    opn = !v[5] && m_pb[5];
    cls = v[5] && !m_pb[5];
    if (opn) begin m_cnt = 0; m_ridx = 0; end
    if (!v[5] && chg) begin
      if (m_dir) begin
        if (m_cnt < 16) begin m_obuf[m_cnt] = m_sr; m_cnt++; m_flag = 1; end
      end else if (m_ridx < m_len) begin
        m_sr = m_ibuf[m_ridx]; m_ridx++; m_flag = 1;
        if (m_ridx >= m_len) m_req = 1;
      end
    end
    m_pkt = 0;
    if (cls) begin m_flag = 1; m_pkt = (m_cnt != 0); end
    m_pb = v;
    wr(2'd0, v);
    chk_all(req);
    m_pkt = 0;
  endtask

  task automatic set_sr(input logic [7:0] d);
    wr(2'd1, d); m_sr = d; chk_all("R11");
  endtask

  task automatic set_mode(input logic [7:0] d);
    wr(2'd2, d); m_dir = d[4];
  endtask

  task automatic clr_flag(input logic [7:0] d);
    wr(2'd3, d); if (d[2]) m_flag = 0; chk_all("R10");
  endtask

  task automatic load_in(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); in_we = 1; in_waddr = 7'(i); in_wdata = 8'($urandom);
      m_ibuf[i] = in_wdata;
    end
    @(negedge clk); in_we = 0; in_go = 1; in_len = 8'(len);
    @(negedge clk); in_go = 0;
    m_len = len; m_ridx = 0; m_req = 0; m_flag = 1;
    chk_all("R7");
  endtask

  task automatic chk_obuf(input string req);
    for (int i = 0; i < m_cnt; i++) begin
      @(negedge clk); out_raddr = 4'(i); #1;
      chk(out_rdata == m_obuf[i], req, out_rdata, m_obuf[i]);
    end
  endtask

  function automatic logic [7:0] pbv(input bit busy, input bit ack);
    logic [7:0] r;
    r = 8'($urandom);
    r[5] = busy; r[4] = ack;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_all("R1");

    // directed output transfer
    set_mode(8'h10);
    set_sr(8'hA5);
    hb(8'hDF, "R8 R4");
    set_sr(8'h3C);
    hb(8'hDF, "R3");            // same pair, no move
    hb(8'hCF, "R4");
    clr_flag(8'h00);
    clr_flag(8'h04);
    hb(8'hC7, "R2");            // bit3 ignored, pair same
    hb(8'hFF, "R9");
    chk_obuf("R4");

    // overflow
    hb(8'hDF, "R8");
    ack = 1;
    for (int i = 0; i < 17; i++) begin
      set_sr(8'($urandom)); clr_flag(8'h04);
      ack = !ack; hb({2'b11, 1'b0, ack, 4'hF}, "R5");
    end
    chk_obuf("R5");
    hb(8'hFF, "R9");

    // input mode, empty outgoing at close
    set_mode(8'h00);
    load_in(3);
    hb(8'hDF, "R6");
    hb(8'hCF, "R6");
    hb(8'hDF, "R6");
    hb(8'hCF, "R6 end");
    clr_flag(8'h04);
    hb(8'hDF, "R6 past");
    hb(8'hFF, "R9 empty");

    // random
    for (int it = 0; it < 200; it++) begin
      int n;
      set_mode(($urandom_range(0, 1) != 0) ? 8'h10 : 8'h00);
      if (!m_dir) load_in($urandom_range(1, 20));
      if ($urandom_range(0, 1) != 0) clr_flag(8'h04);
      ack = $urandom_range(0, 1) != 0;
      hb(pbv(0, ack), "R8");
      n = $urandom_range(1, 20);
      for (int k = 0; k < n; k++) begin
        if (m_dir) set_sr(8'($urandom));
        if ($urandom_range(0, 3) != 0) ack = !ack;
        hb(pbv(0, ack), m_dir ? "R4" : "R6");
      end
      hb(pbv(1, $urandom_range(0, 1) != 0), "R9");
      if (m_dir) chk_obuf("R4");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule